// File: doc/BRIEF.md
# 1-Wire Slot Timing Engine

This block turns one command into a complete, self-timed 1-Wire bus waveform. It can run four operations: a bus reset with presence detection, a write-0 slot, a write-1 slot and a read slot. Each runs at either standard or Overdrive speed. Every duration is counted in ticks of a clock enable that pulses once per 0.25 µs. This makes the fractional timings exact. Each duration is a parameter.

The engine drives an open-drain pulldown enable and samples a line input that has already been synchronized. It reports the sampled bit, presence and short status, and a one-cycle done strobe. It also gives a busy flag and a pulse that marks where an external active pullup may fire. At standard speed an optional mask can hold the bus low across the leading edge of a slave's presence pulse.

The FSM has five states:
- `ST_IDLE` waits for a command.
- `ST_RST_LOW` holds the reset pulse.
- `ST_RST_HIGH` covers the release, the short and presence samples and the optional mask.
- `ST_SLOT_LOW` holds the low part of a bit slot.
- `ST_SLOT_REC` covers the rest of the slot.

The transitions are:
- accept: `ST_IDLE` to `ST_RST_LOW` or `ST_SLOT_LOW`.
- reset release: `ST_RST_LOW` to `ST_RST_HIGH`.
- slot release: `ST_SLOT_LOW` to `ST_SLOT_REC`.
- finish: `ST_RST_HIGH` or `ST_SLOT_REC` back to `ST_IDLE`. The finish transition raises done.

Top module: `owire_slot_engine`

## Requirements
- R1: While rst_n is low and after it is released, pull_low, apu_pulse, busy, done, bit_out, presence and short_flag are all 0.
- R2: cmd_valid is acted on only while busy is low; busy then rises in the next cycle. The operation encodings are 00 reset, 01 write-0, 10 write-1 and 11 read. A command presented while busy has no effect on the waveform or the results.
- R3: A reset holds pull_low for 2400 ticks at standard speed or 288 ticks at Overdrive. It then releases the line, and done follows 2336 ticks (standard) or 296 ticks (Overdrive) after the release.
- R4: During a reset the line is sampled 32 ticks (standard) or 3 ticks (Overdrive) after the release. short_flag becomes 1 if the line was low at that sample and 0 otherwise.
- R5: During a reset the line is sampled 280 ticks (standard) or 30 ticks (Overdrive) after the release. presence becomes 1 if the line was low at that sample and 0 otherwise.
- R6: With mask_en latched high at standard speed, pull_low is asserted again from 40 to 240 ticks after the reset release. At Overdrive, mask_en has no effect.
- R7: A write-0 slot holds pull_low for 256 ticks (standard) or 30 ticks (Overdrive). The slot ends 277 ticks (standard) or 42 ticks (Overdrive) after it starts.
- R8: A write-1 slot and a read slot hold pull_low for 32 ticks (standard) or 4 ticks (Overdrive). The slot ends 277 ticks (standard) or 42 ticks (Overdrive) after it starts.
- R9: In every slot the line is sampled 56 ticks (standard) or 6 ticks (Overdrive) after the slot starts. bit_out takes the line level at that sample.
- R10: speed_fast and mask_en are latched when a command is accepted. Changing them during the command has no effect on it.
- R11: done is a one-cycle strobe in the first cycle that busy is low after a command. bit_out, presence and short_flag change only at their own sample points.
- R12: apu_pulse is high for 8 ticks after the engine releases the line at the end of reset low or slot low. It does not pulse when the presence mask ends.
- R13: A command presented in the cycle of the done strobe is accepted, so busy is low for exactly one cycle between back-to-back commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 0.25 µs clock enable |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation: 00 reset, 01 write-0, 10 write-1, 11 read |
| speed_fast | input | 1 | 1 selects Overdrive timing |
| mask_en | input | 1 | Presence mask enable (standard speed only) |
| line_in | input | 1 | Synchronized bus level |
| pull_low | output | 1 | Open-drain pulldown enable |
| apu_pulse | output | 1 | Active-pullup window after a release |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| bit_out | output | 1 | Sampled slot bit |
| presence | output | 1 | Presence detected at last reset |
| short_flag | output | 1 | Line low at short sample of last reset |

## Verification
Two functions can fall on the same clock edge: the done strobe that ends one command, and the acceptance of the next one. The bench provokes this by holding cmd_valid high across several Overdrive read slots. It judges the result by requiring that busy drops for exactly one cycle and that the next waveform starts on the following edge. It also requires that the previous results stay on the outputs until the new slot's sample point. A behavioural reference model, built on elapsed-tick counts, is compared against every output on every clock throughout.

// File: rtl/owire_pkg.sv
package owire_pkg;

    localparam int TW = 16;

    typedef enum logic [1:0] {
        OP_RESET  = 2'b00,
        OP_WRITE0 = 2'b01,
        OP_WRITE1 = 2'b10,
        OP_READ   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_HIGH,
        ST_SLOT_LOW,
        ST_SLOT_REC
    } state_e;

    typedef struct packed {
        logic [TW-1:0] rst_low;
        logic [TW-1:0] rst_high;
        logic [TW-1:0] short_at;
        logic [TW-1:0] pres_at;
        logic [TW-1:0] w0_low;
        logic [TW-1:0] w1_low;
        logic [TW-1:0] sample_at;
        logic [TW-1:0] slot_len;
        logic [TW-1:0] mask_on;
        logic [TW-1:0] mask_off;
    } times_t;

endpackage

// File: rtl/owire_time_select.sv
module owire_time_select
    import owire_pkg::*;
#(
    parameter int STD_RST_LOW   = 2400,
    parameter int STD_RST_HIGH  = 2336,
    parameter int STD_SHORT_AT  = 32,
    parameter int STD_PRES_AT   = 280,
    parameter int STD_W0_LOW    = 256,
    parameter int STD_W1_LOW    = 32,
    parameter int STD_SAMPLE_AT = 56,
    parameter int STD_SLOT_LEN  = 277,
    parameter int STD_MASK_ON   = 40,
    parameter int STD_MASK_OFF  = 240,
    parameter int FST_RST_LOW   = 288,
    parameter int FST_RST_HIGH  = 296,
    parameter int FST_SHORT_AT  = 3,
    parameter int FST_PRES_AT   = 30,
    parameter int FST_W0_LOW    = 30,
    parameter int FST_W1_LOW    = 4,
    parameter int FST_SAMPLE_AT = 6,
    parameter int FST_SLOT_LEN  = 42
) (
    input  logic   fast_i,
    output times_t times_o
);

    localparam times_t STD_T = '{
        rst_low:   TW'(STD_RST_LOW),
        rst_high:  TW'(STD_RST_HIGH),
        short_at:  TW'(STD_SHORT_AT),
        pres_at:   TW'(STD_PRES_AT),
        w0_low:    TW'(STD_W0_LOW),
        w1_low:    TW'(STD_W1_LOW),
        sample_at: TW'(STD_SAMPLE_AT),
        slot_len:  TW'(STD_SLOT_LEN),
        mask_on:   TW'(STD_MASK_ON),
        mask_off:  TW'(STD_MASK_OFF)
    };

    // Overdrive has no mask window: an empty range keeps it inert.
    localparam times_t FST_T = '{
        rst_low:   TW'(FST_RST_LOW),
        rst_high:  TW'(FST_RST_HIGH),
        short_at:  TW'(FST_SHORT_AT),
        pres_at:   TW'(FST_PRES_AT),
        w0_low:    TW'(FST_W0_LOW),
        w1_low:    TW'(FST_W1_LOW),
        sample_at: TW'(FST_SAMPLE_AT),
        slot_len:  TW'(FST_SLOT_LEN),
        mask_on:   TW'(0),
        mask_off:  TW'(0)
    };

    assign times_o = fast_i ? FST_T : STD_T;

endmodule

// File: rtl/owire_sampler.sv
module owire_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic en_short,
    input  logic en_pres,
    input  logic en_bit,
    input  logic line_i,
    output logic short_o,
    output logic pres_o,
    output logic bit_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_o <= 1'b0;
            pres_o  <= 1'b0;
            bit_o   <= 1'b0;
        end else begin
            if (en_short) short_o <= ~line_i;
            if (en_pres)  pres_o  <= ~line_i;
            if (en_bit)   bit_o   <= line_i;
        end
    end

endmodule

// File: rtl/owire_pullup_timer.sv
module owire_pullup_timer #(
    parameter int APU_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic release_i,
    output logic pulse_o
);

    localparam int AW = $clog2(APU_TICKS + 1);

    logic [AW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (release_i) begin
            left_q <= AW'(APU_TICKS);
        end else if (tick && left_q != '0) begin
            left_q <= left_q - AW'(1);
        end
    end

    assign pulse_o = (left_q != '0);

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
    import owire_pkg::*;
#(
    parameter int STD_RST_LOW   = 2400,
    parameter int STD_RST_HIGH  = 2336,
    parameter int STD_SHORT_AT  = 32,
    parameter int STD_PRES_AT   = 280,
    parameter int STD_W0_LOW    = 256,
    parameter int STD_W1_LOW    = 32,
    parameter int STD_SAMPLE_AT = 56,
    parameter int STD_SLOT_LEN  = 277,
    parameter int STD_MASK_ON   = 40,
    parameter int STD_MASK_OFF  = 240,
    parameter int FST_RST_LOW   = 288,
    parameter int FST_RST_HIGH  = 296,
    parameter int FST_SHORT_AT  = 3,
    parameter int FST_PRES_AT   = 30,
    parameter int FST_W0_LOW    = 30,
    parameter int FST_W1_LOW    = 4,
    parameter int FST_SAMPLE_AT = 6,
    parameter int FST_SLOT_LEN  = 42,
    parameter int APU_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       speed_fast,
    input  logic       mask_en,
    input  logic       line_in,
    output logic       pull_low,
    output logic       apu_pulse,
    output logic       busy,
    output logic       done,
    output logic       bit_out,
    output logic       presence,
    output logic       short_flag
);

    state_e        state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    op_e           op_q;
    logic          fast_q, mask_q, done_q;
    logic          accept, released, finish;
    times_t        tm;
    logic [TW-1:0] low_len;
    logic          in_slot, en_short, en_pres, en_bit;

    owire_time_select #(
        .STD_RST_LOW  (STD_RST_LOW),
        .STD_RST_HIGH (STD_RST_HIGH),
        .STD_SHORT_AT (STD_SHORT_AT),
        .STD_PRES_AT  (STD_PRES_AT),
        .STD_W0_LOW   (STD_W0_LOW),
        .STD_W1_LOW   (STD_W1_LOW),
        .STD_SAMPLE_AT(STD_SAMPLE_AT),
        .STD_SLOT_LEN (STD_SLOT_LEN),
        .STD_MASK_ON  (STD_MASK_ON),
        .STD_MASK_OFF (STD_MASK_OFF),
        .FST_RST_LOW  (FST_RST_LOW),
        .FST_RST_HIGH (FST_RST_HIGH),
        .FST_SHORT_AT (FST_SHORT_AT),
        .FST_PRES_AT  (FST_PRES_AT),
        .FST_W0_LOW   (FST_W0_LOW),
        .FST_W1_LOW   (FST_W1_LOW),
        .FST_SAMPLE_AT(FST_SAMPLE_AT),
        .FST_SLOT_LEN (FST_SLOT_LEN)
    ) u_times (
        .fast_i (fast_q),
        .times_o(tm)
    );

    assign low_len = (op_q == OP_WRITE0) ? tm.w0_low : tm.w1_low;

    // Next-state logic. Slot phases share one counter measured from slot start;
    // reset phases restart the counter at the release.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        accept   = 1'b0;
        released = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept  = 1'b1;
                    cnt_d   = '0;
                    state_d = (op_e'(cmd_op) == OP_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
                end
            end
            ST_RST_LOW: begin
                if (tick) begin
                    if (cnt_q == tm.rst_low - TW'(1)) begin
                        state_d  = ST_RST_HIGH;
                        cnt_d    = '0;
                        released = 1'b1;
                    end else begin
                        cnt_d = cnt_q + TW'(1);
                    end
                end
            end
            ST_RST_HIGH: begin
                if (tick) begin
                    if (cnt_q == tm.rst_high - TW'(1)) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + TW'(1);
                    end
                end
            end
            ST_SLOT_LOW: begin
                if (tick) begin
                    cnt_d = cnt_q + TW'(1);
                    if (cnt_q == low_len - TW'(1)) begin
                        state_d  = ST_SLOT_REC;
                        released = 1'b1;
                    end
                end
            end
            ST_SLOT_REC: begin
                if (tick) begin
                    if (cnt_q == tm.slot_len - TW'(1)) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + TW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_RESET;
            fast_q  <= 1'b0;
            mask_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= finish;
            if (accept) begin
                op_q   <= op_e'(cmd_op);
                fast_q <= speed_fast;
                mask_q <= mask_en;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        pull_low = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_RST_LOW:  pull_low = 1'b1;
            ST_RST_HIGH: pull_low = mask_q && !fast_q &&
                                    (cnt_q >= tm.mask_on) && (cnt_q < tm.mask_off);
            ST_SLOT_LOW: pull_low = 1'b1;
            ST_SLOT_REC: pull_low = 1'b0;
            default:     busy = 1'b0;
        endcase
    end

    assign done = done_q;

    assign in_slot  = (state_q == ST_SLOT_LOW) || (state_q == ST_SLOT_REC);
    assign en_short = tick && (state_q == ST_RST_HIGH) && (cnt_q == tm.short_at);
    assign en_pres  = tick && (state_q == ST_RST_HIGH) && (cnt_q == tm.pres_at);
    assign en_bit   = tick && in_slot && (cnt_q == tm.sample_at);

    owire_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_short(en_short),
        .en_pres (en_pres),
        .en_bit  (en_bit),
        .line_i  (line_in),
        .short_o (short_flag),
        .pres_o  (presence),
        .bit_o   (bit_out)
    );

    owire_pullup_timer #(
        .APU_TICKS(APU_TICKS)
    ) u_pullup (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .release_i(released),
        .pulse_o  (apu_pulse)
    );

endmodule

// File: rtl/owire_slot_checker.sv
module owire_slot_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic pull_low,
    input logic apu_pulse,
    input logic bit_out,
    input logic presence,
    input logic short_flag
);

    // R2: an idle engine takes the command and is busy next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> busy);

    // R11: done lasts a single cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: busy only falls together with done
    p_busy_fall_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11: results hold while no command is running
    p_results_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(bit_out) && $stable(presence) && $stable(short_flag)));

    // R12: the pullup window never overlaps an engine pulldown
    p_apu_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
        apu_pulse |-> !pull_low);

endmodule

bind owire_slot_engine owire_slot_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .pull_low  (pull_low),
    .apu_pulse (apu_pulse),
    .bit_out   (bit_out),
    .presence  (presence),
    .short_flag(short_flag)
);

// File: tb/owire_slot_engine_bench.sv
module owire_slot_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int APU = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       speed_fast = 1'b0;
    logic       mask_en = 1'b0;
    logic       slave_low = 1'b0;
    logic       line_in;
    logic       pull_low, apu_pulse, busy, done, bit_out, presence, short_flag;

    int n_checks = 0;
    int n_errors = 0;
    int tick_div = 1;
    int tcnt = 0;
    int slave_mode = 0;
    string focus = "";

    assign line_in = ~(pull_low | slave_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    owire_slot_engine u_owire_slot_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .speed_fast(speed_fast), .mask_en(mask_en), .line_in(line_in),
        .pull_low(pull_low), .apu_pulse(apu_pulse), .busy(busy), .done(done),
        .bit_out(bit_out), .presence(presence), .short_flag(short_flag)
    );

    // ---------------- behavioural reference model ----------------
    bit m_active = 0, m_fast = 0, m_mask = 0, m_done = 0;
    bit m_bit = 0, m_pres = 0, m_short = 0;
    int m_el = 0, m_kind = 0, m_apu = 0;

    function automatic int rl();  return m_fast ? 288 : 2400; endfunction
    function automatic int rh();  return m_fast ? 296 : 2336; endfunction
    function automatic int sh();  return m_fast ? 3 : 32;     endfunction
    function automatic int pr();  return m_fast ? 30 : 280;   endfunction
    function automatic int smp(); return m_fast ? 6 : 56;     endfunction
    function automatic int slt(); return m_fast ? 42 : 277;   endfunction
    function automatic int lowlen();
        if (m_kind == 1) return m_fast ? 30 : 256;
        return m_fast ? 4 : 32;
    endfunction

    function automatic bit exp_pull();
        if (!m_active) return 1'b0;
        if (m_kind == 0)
            return (m_el < rl()) ||
                   (m_mask && !m_fast && m_el >= rl() + 40 && m_el < rl() + 240);
        return m_el < lowlen();
    endfunction

    always @(posedge clk) begin
        bit load;
        int e;
        load = 1'b0;
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_bit = 0; m_pres = 0; m_short = 0;
            m_el = 0; m_apu = 0; m_fast = 0; m_mask = 0; m_kind = 0;
        end else begin
            m_done = 0;
            if (!m_active) begin
                if (cmd_valid) begin
                    m_active = 1; m_el = 0; m_kind = int'(cmd_op);
                    m_fast = speed_fast; m_mask = mask_en;
                end
            end else if (tick) begin
                e = m_el;
                if (m_kind == 0) begin
                    if (e == rl() - 1)        load = 1'b1;
                    if (e == rl() + sh())     m_short = !line_in;
                    if (e == rl() + pr())     m_pres = !line_in;
                    if (e == rl() + rh() - 1) begin m_done = 1; m_active = 0; end
                end else begin
                    if (e == lowlen() - 1)    load = 1'b1;
                    if (e == smp())           m_bit = line_in;
                    if (e == slt() - 1)       begin m_done = 1; m_active = 0; end
                end
                m_el = e + 1;
            end
            if (load) m_apu = APU;
            else if (tick && m_apu > 0) m_apu = m_apu - 1;
        end
    end

    // ---------------- stimulus helpers ----------------
    always @(negedge clk) begin
        if (tcnt >= tick_div - 1) begin tcnt <= 0; tick <= 1'b1; end
        else begin tcnt <= tcnt + 1; tick <= 1'b0; end
    end

    always @(negedge clk) begin
        case (slave_mode)
            1: slave_low <= m_active && m_kind == 0 &&
                            m_el >= rl() + pr()/2 && m_el < rl() + pr() + 8;
            2: slave_low <= 1'b1;
            3: slave_low <= m_active && m_kind != 0 && m_el < smp() + 4;
            default: slave_low <= 1'b0;
        endcase
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s%s: actual=%0d expected=%0d", tag, what, focus, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        string ptag;
        if (rst_n) begin
            if (m_kind == 0) ptag = (m_mask && !m_fast) ? "R6" : "R3";
            else             ptag = (m_kind == 1) ? "R7" : "R8";
            chk(ptag,  "pull_low",   pull_low,   exp_pull());
            chk("R2",  "busy",       busy,       m_active);
            chk("R11", "done",       done,       m_done);
            chk("R12", "apu_pulse",  apu_pulse,  m_apu > 0);
            chk("R9",  "bit_out",    bit_out,    m_bit);
            chk("R5",  "presence",   presence,   m_pres);
            chk("R4",  "short_flag", short_flag, m_short);
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic f, input logic m, input int mode);
        @(negedge clk);
        slave_mode = mode; cmd_op = op; speed_fast = f; mask_en = m; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL R11 watchdog: done actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "pull_low", pull_low, 0);  chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);          chk("R1", "apu_pulse", apu_pulse, 0);
        chk("R1", "bit_out", bit_out, 0);    chk("R1", "presence", presence, 0);
        chk("R1", "short_flag", short_flag, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R6: reset cycles
        run_cmd(2'b00, 1'b0, 1'b0, 1);   // standard, slave answers
        run_cmd(2'b00, 1'b0, 1'b1, 1);   // standard with mask (R6)
        run_cmd(2'b00, 1'b1, 1'b1, 1);   // Overdrive, mask ignored (R6)
        run_cmd(2'b00, 1'b0, 1'b0, 2);   // shorted line (R4)
        run_cmd(2'b00, 1'b1, 1'b0, 0);   // Overdrive, nobody answers (R5)

        // R7 R8 R9: slots at both speeds
        for (int f = 0; f < 2; f++) begin
            run_cmd(2'b01, f[0], 1'b0, 0);
            run_cmd(2'b10, f[0], 1'b0, 0);
            run_cmd(2'b11, f[0], 1'b0, 0);
            run_cmd(2'b11, f[0], 1'b0, 3);
        end

        // slower tick: 1 in 3 cycles
        tick_div = 3;
        run_cmd(2'b11, 1'b0, 1'b0, 3);
        run_cmd(2'b01, 1'b1, 1'b0, 0);
        run_cmd(2'b00, 1'b1, 1'b0, 1);
        tick_div = 1;

        // R2: command while busy is ignored
        focus = " [R2 busy-ignore]";
        @(negedge clk);
        slave_mode = 0; cmd_op = 2'b10; speed_fast = 1'b0; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        cmd_op = 2'b00; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R2", "busy after ignored cmd", busy, 0);

        // R10: speed and mask changes mid-command have no effect
        focus = " [R10 latch]";
        @(negedge clk);
        slave_mode = 1; cmd_op = 2'b00; speed_fast = 1'b0; mask_en = 1'b1; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        speed_fast = 1'b1; mask_en = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R10", "presence after latched std reset", presence, 1);

        // R13: back-to-back commands, done coincides with acceptance
        focus = " [R13 back-to-back]";
        @(negedge clk);
        slave_mode = 0; cmd_op = 2'b11; speed_fast = 1'b1; mask_en = 1'b0; cmd_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            while (!done) @(negedge clk);
            if (k == 2) cmd_valid = 1'b0;
            @(negedge clk);
            chk("R13", "busy after done", busy, (k < 2) ? 1 : 0);
        end
        focus = "";
        repeat (60) @(negedge clk);
        chk("R13", "bit_out read-back", bit_out, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule